// File: doc/BRIEF.md
# PWM Output Action Qualifier

This block turns time-base events into two pulse-width-modulated output levels, A and B. The event inputs are single-cycle strobes: the counter has reached zero, the counter has reached its period, and the counter matched compare value A or compare value B while counting up. Each output keeps an action word that holds a 2-bit action for each event. An action leaves the output alone, drives it low, drives it high or toggles it. Both outputs are registered and change on the clock edge that samples the event.

A software force register can pin either output to a constant level. Writes to it first land in a shadow copy. They become active at the counter-zero event, at the period event, at either one, or at once, as chosen by the reload field written with the value. While a force is active the output ignores every event. Configuration arrives through a plain single-cycle write port with no back-pressure: every write is accepted in the cycle it is presented.

Top module: `pwm_action_qualifier`

## Requirements
- R1: After reset both outputs are low, every action word is zero, the shadow and active force values are zero (no override), and the reload mode is 00.
- R2: A write is taken in any cycle with `wr_en` high. `wr_addr` 0 selects the action word of output A, 1 selects that of output B, and 2 selects the force register. A write to address 3 changes nothing.
- R3: Action codes are 00 no change, 01 low, 10 high and 11 toggle. In an action word the zero event uses bits 1:0, the period event bits 3:2, compare-A-up bits 5:4 and compare-B-up bits 9:8. The output takes its new level at the clock edge that samples the event.
- R4: When several events arrive in one cycle, the output follows the one with the highest priority among those whose action is not 00. From highest to lowest the order is compare B, compare A, period, zero.
- R5: In the force value, output A uses bits 1:0 and output B uses bits 3:2. Code 01 forces low, 10 forces high, and codes 00 and 11 leave the events in control.
- R6: While an active force code is 01 or 10, the output takes the forced level at the next clock edge and holds it whatever events occur.
- R7: A force write with reload field bits 7:6 equal to 00, 01 or 10 only fills the shadow. The shadow value becomes active at the edge that samples, respectively, a zero event, a period event, or either one. The reload mode stored by the most recent force write decides this.
- R8: A force write with reload field 11 makes its force value active at the same edge that takes the write.
- R9: When a force is released, the output keeps the forced level until an event action changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_zero | input | 1 | Counter-equals-zero strobe |
| evt_period | input | 1 | Counter-equals-period strobe |
| evt_cmpa_up | input | 1 | Compare A match while counting up |
| evt_cmpb_up | input | 1 | Compare B match while counting up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select: 0 action A, 1 action B, 2 force |
| wr_data | input | DATA_W | Write data |
| pwm_out | output | 2 | Output levels, bit 0 is A and bit 1 is B |

## Verification
The assertions take every event and write input to be synchronous to the clock and valid at its rising edge. They do not assume that events exclude one another, because several may coincide. The hold properties assume that no force write and no event occurs in the cycle being judged. The stimulus drives all inputs on the falling edge and holds each for exactly one cycle. It deliberately stacks events to reach the priority cases and interleaves force writes with events.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  localparam int N_OUT    = 2;
  localparam int ACT_W    = 2;
  localparam int FIELDS_W = 4 * ACT_W;
  localparam int FORCE_W  = N_OUT * ACT_W;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO = 2'b00,
    RLD_PRD  = 2'b01,
    RLD_BOTH = 2'b10,
    RLD_NOW  = 2'b11
  } reload_e;

  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/aq_force_shadow.sv
module aq_force_shadow
  import pwm_aq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_force,
  input  logic [FORCE_W-1:0] wr_value,
  input  logic [1:0]         wr_reload,
  input  logic               evt_zero,
  input  logic               evt_period,
  output logic [FORCE_W-1:0] force_active
);

  logic [FORCE_W-1:0] shadow_q;
  reload_e            mode_q;
  logic               load_evt;

  always_comb begin
    case (mode_q)
      RLD_ZERO: load_evt = evt_zero;
      RLD_PRD:  load_evt = evt_period;
      RLD_BOTH: load_evt = evt_zero | evt_period;
      default:  load_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q     <= '0;
      mode_q       <= RLD_ZERO;
      force_active <= '0;
    end else begin
      if (wr_force) begin
        shadow_q <= wr_value;
        mode_q   <= reload_e'(wr_reload);
      end
      if (wr_force && reload_e'(wr_reload) == RLD_NOW)
        force_active <= wr_value;
      else if (load_evt)
        force_active <= shadow_q;
    end
  end

  // R8: an immediate write lands in the active copy on its own edge
  assert_now_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_force && wr_reload == 2'b11) |=> force_active == $past(wr_value));

  // R7: with no write and no reload event the active copy stays put
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_force && !evt_zero && !evt_period) |=> $stable(force_active));

endmodule

// File: rtl/aq_channel.sv
module aq_channel
  import pwm_aq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_act,
  input  logic [FIELDS_W-1:0] act_fields,
  input  logic                evt_zero,
  input  logic                evt_period,
  input  logic                evt_cmpa,
  input  logic                evt_cmpb,
  input  logic [ACT_W-1:0]    force_code,
  output logic                pwm_o
);

  // packed order, low to high: zero, period, compare A, compare B
  logic [FIELDS_W-1:0] fields_q;
  logic [3:0]          evt_vec;
  act_e                win_act;
  logic                pwm_d;

  assign evt_vec = {evt_cmpb, evt_cmpa, evt_period, evt_zero};

  // later slots win: compare B > compare A > period > zero
  always_comb begin
    win_act = ACT_NONE;
    for (int k = 0; k < 4; k++) begin
      if (evt_vec[k] && act_e'(fields_q[k*ACT_W +: ACT_W]) != ACT_NONE)
        win_act = act_e'(fields_q[k*ACT_W +: ACT_W]);
    end
  end

  always_comb begin
    case (act_e'(force_code))
      ACT_LOW:  pwm_d = 1'b0;
      ACT_HIGH: pwm_d = 1'b1;
      default:  pwm_d = apply_act(win_act, pwm_o);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fields_q <= '0;
      pwm_o    <= 1'b0;
    end else begin
      if (wr_act) fields_q <= act_fields;
      pwm_o <= pwm_d;
    end
  end

  assert_force_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_code == 2'b01) |=> !pwm_o);

  assert_force_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_code == 2'b10) |=> pwm_o);

  // R3: no event and no override leaves the level unchanged
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec == 4'b0 && force_code != 2'b01 && force_code != 2'b10) |=> $stable(pwm_o));

endmodule

// File: rtl/pwm_action_qualifier.sv
module pwm_action_qualifier
  import pwm_aq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic              evt_cmpa_up,
  input  logic              evt_cmpb_up,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_OUT-1:0]  pwm_out
);

  localparam logic [ADDR_W-1:0] FORCE_ADDR = ADDR_W'(N_OUT);

  logic [FIELDS_W-1:0] fields_in;
  logic [FORCE_W-1:0]  force_active;
  logic                wr_force;
  logic                unused_hi;

  assign fields_in = {wr_data[9:8], wr_data[5:4], wr_data[3:2], wr_data[1:0]};
  assign unused_hi = ^wr_data[DATA_W-1:10];
  assign wr_force  = wr_en && (wr_addr == FORCE_ADDR);

  aq_force_shadow u_force (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_force     (wr_force),
    .wr_value     (wr_data[FORCE_W-1:0]),
    .wr_reload    (wr_data[7:6]),
    .evt_zero     (evt_zero),
    .evt_period   (evt_period),
    .force_active (force_active)
  );

  for (genvar ch = 0; ch < N_OUT; ch++) begin : g_ch
    aq_channel u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_act     (wr_en && (wr_addr == ADDR_W'(ch))),
      .act_fields (fields_in),
      .evt_zero   (evt_zero),
      .evt_period (evt_period),
      .evt_cmpa   (evt_cmpa_up),
      .evt_cmpb   (evt_cmpb_up),
      .force_code (force_active[ch*ACT_W +: ACT_W]),
      .pwm_o      (pwm_out[ch])
    );
  end

  // R1: outputs are low in the cycle after reset is applied
  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> pwm_out == '0);

endmodule

// File: tb/pwm_action_qualifier_bench.sv
module pwm_action_qualifier_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ez = 0, ep = 0, ea = 0, eb = 0;
  logic        we = 0;
  logic [1:0]  wa = 0;
  logic [15:0] wd = 0;
  logic [1:0]  pwm_out;

  int n_chk = 0;
  int n_fail = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  // bench model state
  logic [15:0] m_word [2];
  logic [3:0]  m_shadow, m_active;
  logic [1:0]  m_mode;
  logic [1:0]  m_out;

  always #4 clk = ~clk;

  pwm_action_qualifier u_pwm_action_qualifier (
    .clk(clk), .rst_n(rst_n),
    .evt_zero(ez), .evt_period(ep), .evt_cmpa_up(ea), .evt_cmpb_up(eb),
    .wr_en(we), .wr_addr(wa), .wr_data(wd), .pwm_out(pwm_out)
  );

  function automatic logic act(input logic [1:0] c, input logic cur);
    case (c)
      2'b01: return 1'b0;
      2'b10: return 1'b1;
      2'b11: return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic model_next(input logic [15:0] w, input logic [1:0] fc,
                                      input logic z, p, a, b, cur);
    logic [1:0] pick;
    if (fc == 2'b01) return 1'b0;
    if (fc == 2'b10) return 1'b1;
    pick = 2'b00;
    if (b && w[9:8] != 0)       pick = w[9:8];
    else if (a && w[5:4] != 0)  pick = w[5:4];
    else if (p && w[3:2] != 0)  pick = w[3:2];
    else if (z && w[1:0] != 0)  pick = w[1:0];
    return act(pick, cur);
  endfunction

  task automatic step(input logic z, p, a, b, input logic w_en,
                      input logic [1:0] addr, input logic [15:0] data, input string tag);
    logic [1:0] nxt;
    logic       ld;
    @(negedge clk);
    ez = z; ep = p; ea = a; eb = b; we = w_en; wa = addr; wd = data;
    for (int c = 0; c < 2; c++)
      nxt[c] = model_next(m_word[c], m_active[2*c +: 2], z, p, a, b, m_out[c]);
    case (m_mode)
      2'd0: ld = z;
      2'd1: ld = p;
      2'd2: ld = z | p;
      default: ld = 1'b0;
    endcase
    if (w_en && addr == 2 && data[7:6] == 2'b11) m_active = data[3:0];
    else if (ld) m_active = m_shadow;
    if (w_en && addr == 2) begin m_shadow = data[3:0]; m_mode = data[7:6]; end
    if (w_en && addr < 2) m_word[addr[0]] = data;
    m_out = nxt;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 2'd0, 16'h0, tag);
  endtask

  task automatic wr(input logic [1:0] addr, input logic [15:0] data, input string tag);
    step(0, 0, 0, 0, 1, addr, data, tag);
  endtask

  // monitor: compares one expected item per clock, after the edge settles
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (pwm_out !== e) begin
        n_fail++;
        $display("FAIL %s: pwm_out=%b expected %b", t, pwm_out, e);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_word[0] = 0; m_word[1] = 0; m_shadow = 0; m_active = 0; m_mode = 0; m_out = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n_chk++;
    if (pwm_out !== 2'b00) begin
      n_fail++;
      $display("FAIL R1: reset pwm_out=%b expected 00", pwm_out);
    end
    // R1: zero action words mean events do nothing
    step(1, 1, 1, 1, 0, 0, 0, "R1");

    // R2/R3 normal polarity
    wr(2'd0, 16'h0018, "R2");
    wr(2'd1, 16'h0108, "R2");
    step(0, 1, 0, 0, 0, 0, 0, "R3 period high");
    step(0, 0, 1, 0, 0, 0, 0, "R3 cmpA low");
    step(0, 0, 0, 1, 0, 0, 0, "R3 cmpB low");
    step(1, 0, 0, 0, 0, 0, 0, "R3 zero none");
    // inverted polarity on A
    wr(2'd0, 16'h0024, "R2");
    step(0, 1, 0, 0, 0, 0, 0, "R3 inv period low");
    step(0, 0, 1, 0, 0, 0, 0, "R3 inv cmpA high");
    // toggle on zero
    wr(2'd0, 16'h0003, "R2");
    step(1, 0, 0, 0, 0, 0, 0, "R3 toggle");
    step(1, 0, 0, 0, 0, 0, 0, "R3 toggle");
    step(1, 0, 0, 0, 0, 0, 0, "R3 toggle");
    // address 3 ignored
    wr(2'd3, 16'h0001, "R2 addr3");
    step(1, 0, 0, 0, 0, 0, 0, "R2 addr3 ignored");
    step(1, 0, 0, 0, 0, 0, 0, "R2 addr3 ignored");

    // R4 priority
    wr(2'd0, 16'h0219, "R2");
    wr(2'd1, 16'h0002, "R2");
    step(1, 0, 0, 0, 0, 0, 0, "R4 zero only");
    step(1, 1, 0, 0, 0, 0, 0, "R4 period over zero");
    step(1, 1, 1, 0, 0, 0, 0, "R4 cmpA over period");
    step(1, 1, 1, 1, 0, 0, 0, "R4 cmpB over cmpA");
    step(0, 0, 1, 0, 0, 0, 0, "R4 cmpA alone");
    step(0, 0, 1, 1, 0, 0, 0, "R4 cmpB wins");
    step(0, 1, 1, 1, 0, 0, 0, "R4 zero-code slots skipped");

    // R7 reload at zero
    wr(2'd2, 16'h0001, "R7 shadow A low");
    idle("R7 not yet active");
    step(0, 1, 0, 0, 0, 0, 0, "R7 period no load");
    step(1, 0, 0, 0, 0, 0, 0, "R7 zero load");
    step(0, 1, 0, 0, 0, 0, 0, "R6 forced low");
    step(1, 1, 1, 1, 0, 0, 0, "R6 forced ignores events");
    // reload at period
    wr(2'd2, 16'h0042, "R7 shadow A high");
    step(1, 0, 0, 0, 0, 0, 0, "R7 zero no load");
    step(0, 1, 0, 0, 0, 0, 0, "R7 period load");
    step(0, 0, 1, 0, 0, 0, 0, "R6 forced high");
    // reload at either
    wr(2'd2, 16'h0088, "R7 shadow B high A free");
    step(1, 0, 0, 0, 0, 0, 0, "R7 either load");
    step(0, 0, 1, 1, 0, 0, 0, "R6 B forced");
    step(0, 0, 1, 0, 0, 0, 0, "R9 A released");
    // immediate
    wr(2'd2, 16'h00C4, "R8 immediate B low");
    idle("R8 B low");
    step(1, 1, 1, 1, 0, 0, 0, "R6 B held low");
    // code 11 means no override
    wr(2'd2, 16'h00CF, "R5 code 11");
    step(1, 0, 0, 0, 0, 0, 0, "R5 events act");
    step(0, 1, 0, 0, 0, 0, 0, "R5 events act");
    // release after a force
    wr(2'd2, 16'h00C8, "R8 B high");
    idle("R6 B high");
    wr(2'd2, 16'h00C0, "R9 release");
    idle("R9 holds level");
    idle("R9 holds level");
    step(0, 0, 1, 1, 0, 0, 0, "R9 events resume");

    @(negedge clk);
    ez = 0; ep = 0; ea = 0; eb = 0; we = 0;
    repeat (3) @(posedge clk);
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule